// File: doc/BRIEF.md
# Calculator Register Display Formatter

This block sits between a classic calculator core and a 16-position seven-segment display. Every clock it reads the core's 14-digit BCD value register and its 14-digit mask register. From them it builds a frame of sixteen segment bytes: fourteen numeric positions, one spare position, and one indicator position at the right. The mask register decides which digits are shown, which are blanked and which carry a decimal point. Two sign digits show a minus sign when they hold a negative code.

Status inputs add three things that sit outside the numeric field. The rightmost position shows a letter while a shift is pending. That position's decimal point shows the speed mode. While the error input is high, a steady error message replaces the number.

The frame is registered. A one-cycle strobe marks every frame that differs from the one before it, so a downstream serial display driver only retransmits when something changed.

Top module: `calc_disp_fmt`

## Requirements
- R1: Display position p (0 leftmost, 0 to 13) shows register digit 13-p, where digit i is bits [4i+3:4i]. Byte bits 0 to 6 are segments a to g and bit 7 is the decimal point, all active high. Digits 0 to 9 use the patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R2: A mask digit of 9 makes its position fully blank (00), including the decimal point.
- R3: A mask digit of 2 sets bit 7 of its position in addition to the digit shown. Any other mask value except 9 shows the digit with bit 7 clear.
- R4: The sign digits are register digits 13 and 2. When not blanked, a sign digit holding 9 shows 40 (segment g only), and one holding 0 shows blank. Other values show normally.
- R5: A non-sign digit holding 10 to 15 shows no segments. Its decimal point still follows R3.
- R6: Position 15 shows F (71) while the first shift flag is high, otherwise G (3D) while the second shift flag is high, otherwise no segments. Position 14 is always 00.
- R7: Bit 7 of position 15 equals the speed flag: 1 for full speed, 0 for real time.
- R8: While the error flag is high, positions 0 to 13 show the text "-- Error --" from position 0, with bytes 40 40 00 79 50 50 5C 50 00 40 40 00 00 00. The value and mask inputs have no effect during this time, and R6 and R7 still apply.
- R9: The frame output reflects the inputs sampled at the previous rising clock edge.
- R10: The update output is high for exactly the cycles whose new frame differs from the frame before it. It stays low while the frame is unchanged.
- R11: During reset the frame is all 00 and update is low. The first clock edge after reset raises update for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| value_i | input | 56 | Displayed-value register, 14 BCD digits |
| mask_i | input | 56 | Per-digit display mask register |
| shift1_i | input | 1 | First shift pending |
| shift2_i | input | 1 | Second shift pending |
| turbo_i | input | 1 | Speed mode, 1 = full speed |
| error_i | input | 1 | Error condition, shows fixed message |
| seg_o | output | 128 | Frame, position p in bits [8p+7:8p] |
| update_o | output | 1 | One-cycle strobe on a changed frame |

## Verification
The value-and-mask patterns are chosen so that each one separates a specific case:
- plain digits against sign digits holding 0 and 9;
- blanked mask against point mask, including a point on a minus sign;
- non-decimal digit codes against ordinary digits;
- each combination of the shift flags, which shows whether F takes priority over G.

An error pattern is applied with indicators active. Its value is then changed underneath it, which separates "input ignored" from "input leaks through". The update strobe is observed on every transition and across a held frame, which separates change detection from a free-running pulse.

// File: rtl/disp_fmt_pkg.sv
package disp_fmt_pkg;
  localparam int SEG_W = 8;
  localparam int DIG_W = 4;
  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_BLANK = 8'h00;
  localparam seg_t SEG_MINUS = 8'h40;
  localparam seg_t SEG_F     = 8'h71;
  localparam seg_t SEG_G     = 8'h3D;
  localparam seg_t SEG_E     = 8'h79;
  localparam seg_t SEG_R     = 8'h50;
  localparam seg_t SEG_O     = 8'h5C;
  localparam seg_t SEG_DP    = 8'h80;

  localparam logic [DIG_W-1:0] MSK_BLANK = 4'd9;
  localparam logic [DIG_W-1:0] MSK_POINT = 4'd2;
  localparam logic [DIG_W-1:0] SIGN_NEG  = 4'd9;
  localparam logic [DIG_W-1:0] SIGN_POS  = 4'd0;

  function automatic seg_t digit_seg(input logic [DIG_W-1:0] d);
    case (d)
      4'd0: return 8'h3F;
      4'd1: return 8'h06;
      4'd2: return 8'h5B;
      4'd3: return 8'h4F;
      4'd4: return 8'h66;
      4'd5: return 8'h6D;
      4'd6: return 8'h7D;
      4'd7: return 8'h07;
      4'd8: return 8'h7F;
      4'd9: return 8'h6F;
      default: return SEG_BLANK;
    endcase
  endfunction

  // fixed message "-- Error --", left aligned
  function automatic seg_t err_msg_seg(input int unsigned pos);
    case (pos)
      0, 1, 9, 10: return SEG_MINUS;
      3:           return SEG_E;
      4, 5, 7:     return SEG_R;
      6:           return SEG_O;
      default:     return SEG_BLANK;
    endcase
  endfunction
endpackage

// File: rtl/disp_digit_cell.sv
module disp_digit_cell
  import disp_fmt_pkg::*;
#(
  parameter bit IS_SIGN = 1'b0,
  parameter int POS     = 0
) (
  input  logic [DIG_W-1:0] val_i,
  input  logic [DIG_W-1:0] msk_i,
  input  logic             err_i,
  output seg_t             seg_o
);
  seg_t glyph;

  generate
    if (IS_SIGN) begin : g_sign
      always_comb begin
        if (val_i == SIGN_NEG)      glyph = SEG_MINUS;
        else if (val_i == SIGN_POS) glyph = SEG_BLANK;
        else                        glyph = digit_seg(val_i);
      end
    end else begin : g_num
      always_comb glyph = digit_seg(val_i);
    end
  endgenerate

  always_comb begin
    if (err_i)                   seg_o = err_msg_seg(POS);
    else if (msk_i == MSK_BLANK) seg_o = SEG_BLANK;
    else if (msk_i == MSK_POINT) seg_o = glyph | SEG_DP;
    else                         seg_o = glyph;
  end
endmodule

// File: rtl/disp_ind_cell.sv
module disp_ind_cell
  import disp_fmt_pkg::*;
(
  input  logic shift1_i,
  input  logic shift2_i,
  input  logic turbo_i,
  output seg_t seg_o
);
  seg_t letter;

  // first shift wins when both are set
  always_comb begin
    if (shift1_i)      letter = SEG_F;
    else if (shift2_i) letter = SEG_G;
    else               letter = SEG_BLANK;
    seg_o = turbo_i ? (letter | SEG_DP) : letter;
  end
endmodule

// File: rtl/disp_frame_reg.sv
module disp_frame_reg #(
  parameter int W = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] frame_i,
  output logic [W-1:0] frame_o,
  output logic         update_o
);
  logic [W-1:0] frame_q;
  logic         upd_q;
  logic         first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      upd_q   <= 1'b0;
      first_q <= 1'b1;
    end else begin
      frame_q <= frame_i;
      upd_q   <= first_q | (frame_i != frame_q);
      first_q <= 1'b0;
    end
  end

  assign frame_o  = frame_q;
  assign update_o = upd_q;

  // R10
  upd_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_q != $past(frame_q)) |-> upd_q);

  // R10
  no_spurious_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(first_q) && $stable(frame_q)) |-> !upd_q);

  // R11
  first_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(first_q) |-> upd_q);
endmodule

// File: rtl/calc_disp_fmt.sv
module calc_disp_fmt
  import disp_fmt_pkg::*;
#(
  parameter int NUM_DIGITS  = 14,
  parameter int SIGN_HI_DIG = 13,
  parameter int SIGN_LO_DIG = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_DIGITS*DIG_W-1:0]   value_i,
  input  logic [NUM_DIGITS*DIG_W-1:0]   mask_i,
  input  logic                          shift1_i,
  input  logic                          shift2_i,
  input  logic                          turbo_i,
  input  logic                          error_i,
  output logic [(NUM_DIGITS+2)*SEG_W-1:0] seg_o,
  output logic                          update_o
);
  localparam int NUM_POS = NUM_DIGITS + 2;
  localparam int GAP_POS = NUM_DIGITS;
  localparam int IND_POS = NUM_DIGITS + 1;
  localparam int FRAME_W = NUM_POS * SEG_W;

  logic [FRAME_W-1:0] frame_d;
  logic               started_q;

  generate
    for (genvar p = 0; p < NUM_DIGITS; p++) begin : g_pos
      localparam int DI = NUM_DIGITS - 1 - p;
      localparam bit SG = (DI == SIGN_HI_DIG) || (DI == SIGN_LO_DIG);
      seg_t cell_seg;

      disp_digit_cell #(.IS_SIGN(SG), .POS(p)) u_cell (
        .val_i (value_i[DI*DIG_W +: DIG_W]),
        .msk_i (mask_i[DI*DIG_W +: DIG_W]),
        .err_i (error_i),
        .seg_o (cell_seg)
      );
      assign frame_d[p*SEG_W +: SEG_W] = cell_seg;

      // R2
      blank_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (started_q && !$past(error_i) && ($past(mask_i[DI*DIG_W +: DIG_W]) == MSK_BLANK))
        |-> (seg_o[p*SEG_W +: SEG_W] == SEG_BLANK));
    end
  endgenerate

  assign frame_d[GAP_POS*SEG_W +: SEG_W] = SEG_BLANK;

  seg_t ind_seg;
  disp_ind_cell u_ind (
    .shift1_i (shift1_i),
    .shift2_i (shift2_i),
    .turbo_i  (turbo_i),
    .seg_o    (ind_seg)
  );
  assign frame_d[IND_POS*SEG_W +: SEG_W] = ind_seg;

  disp_frame_reg #(.W(FRAME_W)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_i  (frame_d),
    .frame_o  (seg_o),
    .update_o (update_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  // R7
  speed_dp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> (seg_o[IND_POS*SEG_W + SEG_W - 1] == $past(turbo_i)));

  // R6
  shift_f_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(shift1_i)) |-> (seg_o[IND_POS*SEG_W +: SEG_W-1] == SEG_F[SEG_W-2:0]));

  // R8
  err_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(error_i)) |-> (seg_o[2*SEG_W-1:0] == {SEG_MINUS, SEG_MINUS}));
endmodule

// File: tb/calc_disp_fmt_test.sv
module calc_disp_fmt_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [55:0]  value = '0;
  logic [55:0]  mask = '0;
  logic         sh1 = 1'b0, sh2 = 1'b0, turbo = 1'b0, err = 1'b0;
  logic [127:0] seg;
  logic         upd;
  int           errs = 0;
  int           checks = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  calc_disp_fmt uut (
    .clk_i(clk), .rst_ni(rst_n), .value_i(value), .mask_i(mask),
    .shift1_i(sh1), .shift2_i(sh2), .turbo_i(turbo), .error_i(err),
    .seg_o(seg), .update_o(upd)
  );

  typedef struct packed {
    logic [55:0] val;
    logic [55:0] msk;
    logic        e, s1, s2, tb;
    logic [7:0]  p0, p1, p11, p13, p15;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{56'h01234567890000, 56'h0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h06, 8'h00, 8'h3F, 8'h00},
    '{56'h91234567890000, 56'h00200000000999, 1'b0, 1'b1, 1'b0, 1'b1, 8'h40, 8'h06, 8'h00, 8'h00, 8'hF1},
    '{56'h00000000000009, 56'h0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h3F, 8'h00, 8'h6F, 8'h3D},
    '{56'h01234567890000, 56'h0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h40, 8'h40, 8'h00, 8'h00, 8'hBD},
    '{56'h00000000000900, 56'h0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h3F, 8'h40, 8'h3F, 8'h71},
    '{56'h0A000000000000, 56'h02000000000000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h80, 8'h00, 8'h3F, 8'h80},
    '{56'h90000000000000, 56'h20000000000000, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC0, 8'h3F, 8'h00, 8'h3F, 8'h00}
  };

  function automatic logic [7:0] pat(input logic [3:0] d);
    logic [7:0] t [10] = '{8'h3F, 8'h06, 8'h5B, 8'h4F, 8'h66, 8'h6D, 8'h7D, 8'h07, 8'h7F, 8'h6F};
    return (d < 4'd10) ? t[d] : 8'h00;
  endfunction

  function automatic logic [127:0] model(input logic [55:0] v, input logic [55:0] m,
                                         input logic e, input logic s1, input logic s2,
                                         input logic tb);
    logic [7:0] msg [14] = '{8'h40, 8'h40, 8'h00, 8'h79, 8'h50, 8'h50, 8'h5C, 8'h50,
                             8'h00, 8'h40, 8'h40, 8'h00, 8'h00, 8'h00};
    logic [127:0] f = '0;
    for (int p = 0; p < 14; p++) begin
      int i = 13 - p;
      logic [3:0] d = v[4*i +: 4];
      logic [3:0] k = m[4*i +: 4];
      logic [7:0] b;
      if (e) b = msg[p];
      else if (k == 4'd9) b = 8'h00;
      else begin
        if ((i == 13 || i == 2) && d == 4'd9) b = 8'h40;
        else if ((i == 13 || i == 2) && d == 4'd0) b = 8'h00;
        else b = pat(d);
        if (k == 4'd2) b[7] = 1'b1;
      end
      f[8*p +: 8] = b;
    end
    f[127:120] = {tb, (s1 ? 7'h71 : (s2 ? 7'h3D : 7'h00))};
    return f;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    // reset state
    mask = 56'h99999999999999;
    repeat (3) @(negedge clk);
    chk("R11 reset frame", seg, '0);
    chk("R11 reset update", {127'd0, upd}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 first strobe", {127'd0, upd}, 128'd1);
    chk("R11 blank after reset", seg, '0);
    @(negedge clk);
    chk("R11 single strobe", {127'd0, upd}, 128'd0);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R10 held frame no strobe", {127'd0, upd}, 128'd0);
    end

    // table walk
    for (int n = 0; n < NV; n++) begin
      value = VECS[n].val; mask = VECS[n].msk; err = VECS[n].e;
      sh1 = VECS[n].s1; sh2 = VECS[n].s2; turbo = VECS[n].tb;
      @(negedge clk);
      chk("R9 R10 strobe on change", {127'd0, upd}, 128'd1);
      chk("R1 pos0", {120'd0, seg[7:0]}, {120'd0, VECS[n].p0});
      chk("R3 R5 pos1", {120'd0, seg[15:8]}, {120'd0, VECS[n].p1});
      chk("R4 pos11", {120'd0, seg[95:88]}, {120'd0, VECS[n].p11});
      chk("R2 pos13", {120'd0, seg[111:104]}, {120'd0, VECS[n].p13});
      chk("R6 R7 pos15", {120'd0, seg[127:120]}, {120'd0, VECS[n].p15});
      chk("R8 full frame", seg, model(value, mask, err, sh1, sh2, turbo));
      @(negedge clk);
      chk("R10 strobe one cycle", {127'd0, upd}, 128'd0);
    end

    // error ignores value and mask
    value = 56'h01234567890000; mask = '0; err = 1'b1; sh1 = 1'b1; sh2 = 1'b0; turbo = 1'b0;
    repeat (2) @(negedge clk);
    held = seg;
    chk("R8 error with F", seg, model(value, mask, 1'b1, 1'b1, 1'b0, 1'b0));
    value = 56'h98765432109999; mask = 56'h22222222229999;
    @(negedge clk);
    chk("R8 value ignored frame", seg, held);
    chk("R8 value ignored strobe", {127'd0, upd}, 128'd0);

    // full digit walk
    err = 1'b0; sh1 = 1'b0; value = 56'h50123456789876; mask = 56'h00000000020000;
    @(negedge clk);
    chk("R1 digit walk", seg, model(value, mask, 1'b0, 1'b0, 1'b0, 1'b0));
    chk("R1 pos13 six", {120'd0, seg[111:104]}, {120'd0, 8'h7D});
    chk("R6 pos14 blank", {120'd0, seg[119:112]}, 128'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule